// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the time of day and the calendar as packed BCD bytes and steps them forward once for every pulse of a one-second strobe. The fields are seconds, minutes, hours, day of month, day of week, month and a two-digit year. Carries ripple through them in a single clock cycle. The day of month wraps at the end of each month. That end depends on the month, and for February also on the year.

A host reads and sets every field through a byte-wide register port. Writes are single-cycle strobes. Reads are combinational from the address. Both are plain control pins with no handshake, and no back-pressure ever applies.

A control register selects either 24-hour coding or 12-hour coding with a PM bit. The same register can freeze the counters or request a software reset. A sticky clock-integrity flag shares the seconds byte. It records that the oscillator stopped, and only a host write of seconds clears it.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read: control 0x00, seconds 0x80 (integrity flag set, count 00), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00.
- R2: Addresses are: control at 0x0, and seconds, minutes, hours, date, weekday, month, year at 0x3 through 0x9 in that order. Every other address reads 0x00.
- R3: Each accepted tick adds one to seconds. Seconds 59 become 00 and carry into minutes. Minutes 59 become 00 and carry into hours.
- R4: With control bit 3 at 0 (24-hour), hours count 00 to 23. The 23 to 00 step carries into both date and weekday.
- R5: With control bit 3 at 1 (12-hour), bits 4:0 of hours hold BCD 01 to 12 and bit 5 is PM. The count runs 11, 12, 01, and PM toggles on the 11 to 12 step. The day carries only on 11 PM to 12 AM.
- R6: Date wraps to 01 after day 31 for months 01, 03, 05, 07, 08, 10 and 12, after day 30 for months 04, 06, 09 and 11, and after day 29 for February when the decimal year is divisible by 4 (28 otherwise). The wrap advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: Weekday counts 0 to 6 and wraps 6 to 0 on each day carry, independently of date.
- R8: While control bit 5 is 1, ticks change no time field.
- R9: Seconds bit 7 is the integrity flag. The osc_fail input sets it, and it stays set while the time advances. A seconds write loads it from data bit 7, so writing bit 7 as 0 clears it.
- R10: A host write to any time field in the same cycle as a tick takes priority. The written value is stored, that tick is dropped, and the other fields keep their values.
- R11: Writing control with bit 4 at 1 is a software reset. Control and all time fields return to their R1 values, but the integrity flag is kept. Bit 4 always reads 0.
- R12: Unused bits read 0. The stored widths are: minutes 7 bits, hours 6 bits, date 6 bits, weekday 3 bits, month 5 bits, year 8 bits, and control bits 3 and 5 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| osc_fail | input | 1 | Oscillator-stopped indication; sets the integrity flag |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | ADDR_W (4) | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr |

## Verification
The bench builds the block with its default 4-bit address. That gives a sixteen-slot map, so the unmapped holes below and above the time fields can be read. The one-second strobe is driven directly from the bench, and the fields can be preset to the last second of any day. Month-end wraps, leap and non-leap Februaries (including BCD year 10, which a raw low-bit test would misjudge) and the year 99 wrap each take a single tick to reach.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int ADR_CTRL = 0;
  localparam int ADR_SEC  = 3;
  localparam int ADR_MIN  = 4;
  localparam int ADR_HR   = 5;
  localparam int ADR_DATE = 6;
  localparam int ADR_WDAY = 7;
  localparam int ADR_MON  = 8;
  localparam int ADR_YEAR = 9;

  // two-digit BCD increment (no wrap handling)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

  // BCD number of the final day of a month
  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic [6:0] yb;
    yb = bcd_to_bin(yr);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
  parameter int             W     = 8,
  parameter logic [W-1:0]   FIRST = '0,
  parameter logic [W-1:0]   LAST  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         adv,
  output logic [W-1:0] val,
  output logic         carry
);
  import rtc_cal_pkg::*;

  logic at_end;
  assign at_end = (val >= LAST);
  assign carry  = adv & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= FIRST;
    else if (clr) val <= FIRST;
    else if (wr)  val <= wdata;
    else if (adv) val <= at_end ? FIRST : W'(bcd_inc(8'(val)));
  end

  // R3: a counter at its last value returns to its first value on advance
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && !clr && val == LAST) |=> (val == FIRST));
endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr,
  input  logic [5:0] wdata,
  input  logic       adv,
  input  logic       mode12,
  output logic [5:0] hr,
  output logic       day_carry
);
  import rtc_cal_pkg::*;

  logic [5:0] nxt;
  logic       last_hour;

  always_comb begin
    if (mode12) begin
      if (hr[4:0] == 5'h12)      nxt = {hr[5], 5'h01};
      else if (hr[4:0] == 5'h11) nxt = {~hr[5], 5'h12};
      else                       nxt = {hr[5], 5'(bcd_inc(8'(hr[4:0])))};
    end else begin
      nxt = (hr >= 6'h23) ? 6'h00 : 6'(bcd_inc(8'(hr)));
    end
  end

  assign last_hour = mode12 ? (hr[5] && hr[4:0] == 5'h11) : (hr >= 6'h23);
  assign day_carry = adv & last_hour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hr <= 6'h00;
    else if (clr) hr <= 6'h00;
    else if (wr)  hr <= wdata;
    else if (adv) hr <= nxt;
  end

  // R5: the 11 -> 12 step in 12-hour coding flips the PM bit
  assert_pm_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode12 && adv && !wr && !clr && hr[4:0] == 5'h11) |=> (hr[5] != $past(hr[5])));
  // R4: 23 in 24-hour coding returns to 00
  assert_day_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode12 && adv && !wr && !clr && hr == 6'h23) |=> (hr == 6'h00));
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_date,
  input  logic       wr_mon,
  input  logic       wr_year,
  input  logic [7:0] wdata,
  input  logic       adv_day,
  output logic [5:0] date,
  output logic [4:0] month,
  output logic [7:0] year
);
  import rtc_cal_pkg::*;

  logic [7:0] last_day;
  logic       roll;
  logic       mon_adv;
  logic       year_adv;
  logic       year_carry_unused;

  assign last_day = month_last_day(8'(month), year);
  assign roll     = (8'(date) >= last_day);
  assign mon_adv  = adv_day & roll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       date <= 6'h01;
    else if (clr)     date <= 6'h01;
    else if (wr_date) date <= wdata[5:0];
    else if (adv_day) date <= roll ? 6'h01 : 6'(bcd_inc(8'(date)));
  end

  rtc_bcd_wrap #(.W(5), .FIRST(5'h01), .LAST(5'h12)) u_month (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr_mon), .wdata(wdata[4:0]),
    .adv(mon_adv), .val(month), .carry(year_adv));

  rtc_bcd_wrap #(.W(8), .FIRST(8'h00), .LAST(8'h99)) u_year (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr_year), .wdata(wdata),
    .adv(year_adv), .val(year), .carry(year_carry_unused));

  // R6: a day carry on the month's final day gives date 01
  assert_date_roll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_day && !wr_date && !clr && 8'(date) == last_day) |=> (date == 6'h01));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int ADDR_W = rtc_cal_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_fail,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  import rtc_cal_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADR_SEC);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(ADR_MIN);
  localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(ADR_HR);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(ADR_DATE);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(ADR_WDAY);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(ADR_MON);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(ADR_YEAR);

  logic       mode12_q, stop_q, flag_q;
  logic       wr_ctrl, soft_rst, wr_time;
  logic       wr_sec, wr_min, wr_hr, wr_date, wr_wday, wr_mon, wr_year;
  logic       adv_sec, c_sec, c_min, c_day, c_wday_unused;
  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, date_q;
  logic [2:0] wday_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;

  assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
  assign wr_sec   = reg_we && reg_addr == A_SEC;
  assign wr_min   = reg_we && reg_addr == A_MIN;
  assign wr_hr    = reg_we && reg_addr == A_HR;
  assign wr_date  = reg_we && reg_addr == A_DATE;
  assign wr_wday  = reg_we && reg_addr == A_WDAY;
  assign wr_mon   = reg_we && reg_addr == A_MON;
  assign wr_year  = reg_we && reg_addr == A_YEAR;
  assign wr_time  = wr_sec | wr_min | wr_hr | wr_date | wr_wday | wr_mon | wr_year;
  assign soft_rst = wr_ctrl && reg_wdata[4];
  // a host write to time, a stop or a reset drops the tick
  assign adv_sec  = tick_1hz && !stop_q && !wr_time && !soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode12_q <= 1'b0;
      stop_q   <= 1'b0;
    end else if (soft_rst) begin
      mode12_q <= 1'b0;
      stop_q   <= 1'b0;
    end else if (wr_ctrl) begin
      mode12_q <= reg_wdata[3];
      stop_q   <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (osc_fail) flag_q <= 1'b1;
    else if (wr_sec)  flag_q <= reg_wdata[7];
  end

  rtc_bcd_wrap #(.W(7), .FIRST(7'h00), .LAST(7'h59)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr(wr_sec), .wdata(reg_wdata[6:0]),
    .adv(adv_sec), .val(sec_q), .carry(c_sec));

  rtc_bcd_wrap #(.W(7), .FIRST(7'h00), .LAST(7'h59)) u_min (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr(wr_min), .wdata(reg_wdata[6:0]),
    .adv(c_sec), .val(min_q), .carry(c_min));

  rtc_hour_unit u_hour (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr(wr_hr), .wdata(reg_wdata[5:0]),
    .adv(c_min), .mode12(mode12_q), .hr(hr_q), .day_carry(c_day));

  rtc_bcd_wrap #(.W(3), .FIRST(3'd0), .LAST(3'd6)) u_wday (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr(wr_wday), .wdata(reg_wdata[2:0]),
    .adv(c_day), .val(wday_q), .carry(c_wday_unused));

  rtc_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wr_date(wr_date), .wr_mon(wr_mon),
    .wr_year(wr_year), .wdata(reg_wdata), .adv_day(c_day),
    .date(date_q), .month(mon_q), .year(year_q));

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {2'b00, stop_q, 1'b0, mode12_q, 3'b000};
      A_SEC:   reg_rdata = {flag_q, sec_q};
      A_MIN:   reg_rdata = {1'b0, min_q};
      A_HR:    reg_rdata = {2'b00, hr_q};
      A_DATE:  reg_rdata = {2'b00, date_q};
      A_WDAY:  reg_rdata = {5'b00000, wday_q};
      A_MON:   reg_rdata = {3'b000, mon_q};
      A_YEAR:  reg_rdata = year_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  // R8: stopped and untouched by the host, no field moves
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !reg_we) |=> $stable({sec_q, min_q, hr_q, date_q, wday_q, mon_q, year_q}));
  // R9: the flag survives anything but a seconds write
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_sec) |=> flag_q);
  // R10: a colliding minutes write leaves seconds alone
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_min && tick_1hz) |=> (sec_q == $past(sec_q)));
  // R11: bit 4 of control never reads back
  assert_no_reset_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> !reg_rdata[4]);
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       osc_fail = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  rtc_calendar_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_fail(osc_fail),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic fail_osc();
    @(negedge clk); osc_fail = 1'b1;
    @(negedge clk); osc_fail = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    vectors++;
    if (reg_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s addr %0h got %02h expected %02h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, w, h, m, s);
    wr(4'h9, y); wr(4'h8, mo); wr(4'h6, d); wr(4'h7, w);
    wr(4'h5, h); wr(4'h4, m); wr(4'h3, s);
  endtask

  task automatic t_reset();
    chk("R1", 4'h0, 8'h00); chk("R1", 4'h3, 8'h80); chk("R1", 4'h4, 8'h00);
    chk("R1", 4'h5, 8'h00); chk("R1", 4'h6, 8'h01); chk("R1", 4'h7, 8'h00);
    chk("R1", 4'h8, 8'h01); chk("R1", 4'h9, 8'h00);
    chk("R2", 4'h1, 8'h00); chk("R2", 4'h2, 8'h00); chk("R2", 4'hA, 8'h00);
  endtask

  task automatic t_flag();
    tick();          chk("R9", 4'h3, 8'h81);
    wr(4'h3, 8'h10); chk("R9", 4'h3, 8'h10);
    tick();          chk("R9", 4'h3, 8'h11);
    fail_osc();      chk("R9", 4'h3, 8'h91);
    tick();          chk("R9", 4'h3, 8'h92);
    wr(4'h3, 8'h85); chk("R9", 4'h3, 8'h85);
    wr(4'h3, 8'h25); chk("R9", 4'h3, 8'h25);
  endtask

  task automatic t_sec_min();
    set_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h05, 8'h59, 8'h58);
    tick(); chk("R3", 4'h3, 8'h59); chk("R3", 4'h4, 8'h59);
    tick(); chk("R3", 4'h3, 8'h00); chk("R3", 4'h4, 8'h00);
    chk("R3", 4'h5, 8'h06); chk("R3", 4'h6, 8'h01);
  endtask

  task automatic t_day24();
    set_time(8'h24, 8'h03, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R4", 4'h5, 8'h00); chk("R4", 4'h6, 8'h16);
    chk("R7", 4'h7, 8'h00); chk("R4", 4'h8, 8'h03); chk("R4", 4'h9, 8'h24);
  endtask

  task automatic t_12h();
    wr(4'h0, 8'h08); chk("R5", 4'h0, 8'h08);
    set_time(8'h24, 8'h03, 8'h05, 8'h02, 8'h11, 8'h59, 8'h59);
    tick(); chk("R5", 4'h5, 8'h32); chk("R5", 4'h6, 8'h05);
    set_time(8'h24, 8'h03, 8'h05, 8'h02, 8'h32, 8'h59, 8'h59);
    tick(); chk("R5", 4'h5, 8'h21);
    set_time(8'h24, 8'h03, 8'h05, 8'h02, 8'h12, 8'h59, 8'h59);
    tick(); chk("R5", 4'h5, 8'h01);
    set_time(8'h24, 8'h03, 8'h05, 8'h02, 8'h31, 8'h59, 8'h59);
    tick(); chk("R5", 4'h5, 8'h12); chk("R5", 4'h6, 8'h06); chk("R7", 4'h7, 8'h03);
    wr(4'h0, 8'h00);
  endtask

  task automatic month_case(input logic [7:0] y, mo, d, ey, emo, ed);
    set_time(y, mo, d, 8'h00, 8'h23, 8'h59, 8'h59);
    tick();
    chk("R6", 4'h6, ed); chk("R6", 4'h8, emo); chk("R6", 4'h9, ey);
  endtask

  task automatic t_months();
    month_case(8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29);
    month_case(8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01);
    month_case(8'h23, 8'h02, 8'h28, 8'h23, 8'h03, 8'h01);
    month_case(8'h10, 8'h02, 8'h28, 8'h10, 8'h03, 8'h01);
    month_case(8'h12, 8'h02, 8'h28, 8'h12, 8'h02, 8'h29);
    month_case(8'h25, 8'h04, 8'h30, 8'h25, 8'h05, 8'h01);
    month_case(8'h25, 8'h03, 8'h30, 8'h25, 8'h03, 8'h31);
    month_case(8'h25, 8'h01, 8'h31, 8'h25, 8'h02, 8'h01);
    month_case(8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01);
  endtask

  task automatic t_stop();
    set_time(8'h25, 8'h06, 8'h10, 8'h01, 8'h08, 8'h15, 8'h20);
    wr(4'h0, 8'h20);
    tick(); tick(); tick();
    chk("R8", 4'h3, 8'h20); chk("R8", 4'h4, 8'h15);
    wr(4'h0, 8'h00);
    tick(); chk("R8", 4'h3, 8'h21);
  endtask

  task automatic t_collide();
    set_time(8'h25, 8'h06, 8'h10, 8'h01, 8'h08, 8'h05, 8'h10);
    @(negedge clk);
    tick_1hz = 1'b1; reg_we = 1'b1; reg_addr = 4'h4; reg_wdata = 8'h30;
    @(negedge clk);
    tick_1hz = 1'b0; reg_we = 1'b0;
    chk("R10", 4'h3, 8'h10); chk("R10", 4'h4, 8'h30); chk("R10", 4'h5, 8'h08);
    tick(); chk("R10", 4'h3, 8'h11);
  endtask

  task automatic t_softrst();
    set_time(8'h24, 8'h07, 8'h14, 8'h03, 8'h12, 8'h34, 8'h56);
    fail_osc();
    wr(4'h0, 8'h18);
    chk("R11", 4'h0, 8'h00); chk("R11", 4'h3, 8'h80); chk("R11", 4'h4, 8'h00);
    chk("R11", 4'h5, 8'h00); chk("R11", 4'h6, 8'h01); chk("R11", 4'h7, 8'h00);
    chk("R11", 4'h8, 8'h01); chk("R11", 4'h9, 8'h00);
  endtask

  task automatic t_masks();
    wr(4'h4, 8'hFF); chk("R12", 4'h4, 8'h7F);
    wr(4'h5, 8'hFF); chk("R12", 4'h5, 8'h3F);
    wr(4'h6, 8'hFF); chk("R12", 4'h6, 8'h3F);
    wr(4'h7, 8'hFF); chk("R12", 4'h7, 8'h07);
    wr(4'h8, 8'hFF); chk("R12", 4'h8, 8'h1F);
    wr(4'h0, 8'hEF); chk("R12", 4'h0, 8'h28);
    wr(4'h0, 8'h00); chk("R12", 4'h0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flag();
    t_sec_min();
    t_day24();
    t_12h();
    t_months();
    t_stop();
    t_collide();
    t_softrst();
    t_masks();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule